// File: doc/BRIEF.md
# Disk Sector Address Sequencer

This block holds the cylinder, head and sector address of a moving-head disk controller and walks them forward across sector boundaries while a transfer runs. The host places a starting address with a load strobe and a packed data bus. Each sector-end pulse then moves the address to the next sector. The sector count wraps inside a track, the head count wraps inside a cylinder, and the cylinder count wraps at the end of the pack, where a sticky end-of-pack bit is raised.

The sector step is withheld while any transfer error is latched or while the controller is formatting. A maintenance input steps the address without regard to those conditions. For the whole-track functions (read-all and write-all), the head changes one sector earlier than for ordinary transfers. Three range decoders flag addresses past their limits, so a bad address placed by the host is caught before the seek.

Top module: `disk_addr_seq`

## Requirements
- R1: While `rst_n` is low, cylinder, head and sector are 0 and `end_of_pack` is 0.
- R2: A `sector_end` pulse with all four error inputs low and `fmt_mode` low adds one to the sector. At SEC_MAX it sets the sector to 0 instead.
- R3: A `sector_end` pulse while any of `err_write`, `err_parity`, `err_wcheck` or `err_timing` is high leaves cylinder, head and sector unchanged.
- R4: A `sector_end` pulse while `fmt_mode` is high leaves cylinder, head and sector unchanged.
- R5: For `func` codes 0 (read), 1 (write), 2 (write check) and 5 to 7, the head advances on the step that wraps the sector from SEC_MAX to 0.
- R6: For `func` codes 3 (read all) and 4 (write all), the head advances on the step taken while the sector equals SEC_MAX-1. It does not advance on the wrap.
- R7: A head advance at HEAD_MAX sets the head to 0 and adds one to the cylinder.
- R8: A cylinder advance at CYL_MAX sets the cylinder to 0 and sets `end_of_pack`. `end_of_pack` stays set until a clear or a load.
- R9: A `maint_step` pulse steps the address as in R2, R5 to R8, whatever the error inputs and `fmt_mode` are.
- R10: `clr` zeroes all three addresses and `end_of_pack`. `load` copies `load_data` as {cylinder in the top CW bits, head in the next HW bits, sector in the low SW bits} and clears `end_of_pack`. `clr` wins over `load`, and both win over any step in the same cycle.
- R11: `bad_cyl`, `bad_head` and `bad_sec` are high exactly while the matching address exceeds CYL_MAX, HEAD_MAX or SEC_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | General clear |
| load | input | 1 | Host load strobe |
| load_data | input | CW+HW+SW | Packed address for load |
| sector_end | input | 1 | One-cycle end-of-sector pulse |
| maint_step | input | 1 | One-cycle maintenance step |
| err_write | input | 1 | Latched write error |
| err_parity | input | 1 | Latched longitudinal parity error |
| err_wcheck | input | 1 | Latched write-check error |
| err_timing | input | 1 | Latched timing error |
| fmt_mode | input | 1 | 1 = format mode, 0 = normal |
| func | input | 3 | Function code |
| cyl | output | CW | Cylinder address |
| head | output | HW | Head address |
| sec | output | SW | Sector address |
| end_of_pack | output | 1 | Sticky end-of-pack flag |
| bad_cyl | output | 1 | Cylinder out of range |
| bad_head | output | 1 | Head out of range |
| bad_sec | output | 1 | Sector out of range |

## Verification
The bench keeps the register widths and the sector and head limits at their defaults and lowers CYL_MAX to 4. A whole pack is then 1000 sectors, so it walks every address of the pack, through the end-of-pack wrap, once for ordinary functions and once for whole-track functions, and compares each step with a position computed from the step count. Because the widths are unchanged, the loads sweep every cylinder, head and sector code the registers can hold. That covers the illegal-address decoders over their full range, including the codes above the lowered cylinder limit.

// File: rtl/disk_addr_seq.sv
module disk_addr_seq #(
  parameter int CW       = 8,
  parameter int HW       = 5,
  parameter int SW       = 4,
  parameter int CYL_MAX  = 202,
  parameter int HEAD_MAX = 19,
  parameter int SEC_MAX  = 9,
  localparam int BW      = CW + HW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [BW-1:0] load_data,
  input  logic          sector_end,
  input  logic          maint_step,
  input  logic          err_write,
  input  logic          err_parity,
  input  logic          err_wcheck,
  input  logic          err_timing,
  input  logic          fmt_mode,
  input  logic [2:0]    func,
  output logic [CW-1:0] cyl,
  output logic [HW-1:0] head,
  output logic [SW-1:0] sec,
  output logic          end_of_pack,
  output logic          bad_cyl,
  output logic          bad_head,
  output logic          bad_sec
);

  localparam logic [CW-1:0] C_TOP = CW'(CYL_MAX);
  localparam logic [HW-1:0] H_TOP = HW'(HEAD_MAX);
  localparam logic [SW-1:0] S_TOP = SW'(SEC_MAX);
  localparam logic [SW-1:0] S_PRE = SW'(SEC_MAX - 1);

  logic any_err, step, whole_trk, head_step, cyl_step, pack_wrap;

  assign any_err   = err_write | err_parity | err_wcheck | err_timing;
  assign step      = maint_step | (sector_end & ~any_err & ~fmt_mode);
  assign whole_trk = (func == 3'd3) || (func == 3'd4);
  assign head_step = step & (whole_trk ? (sec == S_PRE) : (sec == S_TOP));
  assign cyl_step  = head_step & (head == H_TOP);
  assign pack_wrap = cyl_step & (cyl == C_TOP);

  assign bad_cyl  = cyl  > C_TOP;
  assign bad_head = head > H_TOP;
  assign bad_sec  = sec  > S_TOP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyl <= '0; head <= '0; sec <= '0; end_of_pack <= 1'b0;
    end else if (clr) begin
      cyl <= '0; head <= '0; sec <= '0; end_of_pack <= 1'b0;
    end else if (load) begin
      {cyl, head, sec} <= load_data;
      end_of_pack <= 1'b0;
    end else begin
      if (step)      sec  <= (sec == S_TOP)  ? '0 : sec + 1'b1;
      if (head_step) head <= (head == H_TOP) ? '0 : head + 1'b1;
      if (cyl_step)  cyl  <= (cyl == C_TOP)  ? '0 : cyl + 1'b1;
      if (pack_wrap) end_of_pack <= 1'b1;
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && maint_step && sec == S_TOP) |=> (sec == '0)); // R9

  AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !maint_step && (fmt_mode || any_err))
      |=> ($stable(sec) && $stable(head) && $stable(cyl))); // R3

  AST_HEAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !maint_step && !sector_end) |=> $stable(head)); // R6

  AST_EOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (end_of_pack && !clr && !load) |=> end_of_pack); // R8

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cyl == '0 && head == '0 && sec == '0 && !end_of_pack)); // R10

endmodule

// File: tb/sim_disk_addr_seq.sv
module sim_disk_addr_seq;
  localparam int CW = 8, HW = 5, SW = 4;
  localparam int CMAX = 4, HMAX = 19, SMAX = 9;
  localparam int BW = CW + HW + SW;

  logic clk = 0, rst_n = 0, clr = 0, load = 0;
  logic [BW-1:0] load_data = '0;
  logic sector_end = 0, maint_step = 0;
  logic err_write = 0, err_parity = 0, err_wcheck = 0, err_timing = 0, fmt_mode = 0;
  logic [2:0] func = 0;
  logic [CW-1:0] cyl;
  logic [HW-1:0] head;
  logic [SW-1:0] sec;
  logic end_of_pack, bad_cyl, bad_head, bad_sec;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  disk_addr_seq #(.CW(CW), .HW(HW), .SW(SW), .CYL_MAX(CMAX), .HEAD_MAX(HMAX), .SEC_MAX(SMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_data(load_data),
    .sector_end(sector_end), .maint_step(maint_step), .err_write(err_write),
    .err_parity(err_parity), .err_wcheck(err_wcheck), .err_timing(err_timing),
    .fmt_mode(fmt_mode), .func(func), .cyl(cyl), .head(head), .sec(sec),
    .end_of_pack(end_of_pack), .bad_cyl(bad_cyl), .bad_head(bad_head), .bad_sec(bad_sec));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic chk_addr(string req, int c, int h, int s, int e);
    chk({req, " cyl"}, int'(cyl), c);
    chk({req, " head"}, int'(head), h);
    chk({req, " sec"}, int'(sec), s);
    chk({req, " eop"}, int'(end_of_pack), e);
  endtask

  // one clock with the given strobes; inputs set and outputs sampled on falling edges
  task automatic pulse(logic se, logic ms, logic cl, logic ld);
    sector_end = se; maint_step = ms; clr = cl; load = ld;
    @(negedge clk);
    sector_end = 0; maint_step = 0; clr = 0; load = 0;
  endtask

  task automatic do_load(int c, int h, int s);
    load_data = {CW'(c), HW'(h), SW'(s)};
    pulse(0, 0, 0, 1);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hc;
    @(negedge clk);
    chk_addr("R1 reset", 0, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R5 R7 R8: full-pack walk with ordinary functions
    func = 3'd0;
    for (int k = 1; k <= 1010; k++) begin
      pulse(1, 0, 0, 0);
      hc = k / 10;
      chk_addr("R5 walk", (hc / 20) % (CMAX + 1), hc % 20, k % 10, int'(hc >= 100));
    end
    chk("R8 sticky", int'(end_of_pack), 1);
    pulse(0, 0, 1, 0);
    chk_addr("R10 clr", 0, 0, 0, 0);

    // R6: whole-track functions move the head after sector 8
    func = 3'd3;
    for (int k = 1; k <= 1010; k++) begin
      pulse(1, 0, 0, 0);
      hc = (k + 1) / 10;
      chk_addr("R6 walk", (hc / 20) % (CMAX + 1), hc % 20, k % 10, int'(hc >= 100));
      if (k == 1000) func = 3'd4;
    end
    do_load(2, 5, 9);
    pulse(1, 0, 0, 0);
    chk_addr("R6 no head on wrap", 2, 5, 0, 0);
    func = 3'd2;
    do_load(2, 5, 8);
    pulse(1, 0, 0, 0);
    chk_addr("R5 no head at 8", 2, 5, 9, 0);
    pulse(1, 0, 0, 0);
    chk_addr("R5 head on wrap", 2, 6, 0, 0);
    func = 3'd0;

    // R7 R8: corner carries
    do_load(1, 19, 9);
    pulse(1, 0, 0, 0);
    chk_addr("R7 head carry", 2, 0, 0, 0);
    do_load(4, 19, 9);
    pulse(1, 0, 0, 0);
    chk_addr("R8 pack wrap", 0, 0, 0, 1);
    pulse(1, 0, 0, 0);
    chk("R8 stays set", int'(end_of_pack), 1);
    do_load(1, 1, 1);
    chk("R10 load clears eop", int'(end_of_pack), 0);

    // R3: each error blocks
    for (int e = 0; e < 4; e++) begin
      do_load(3, 19, 9);
      {err_write, err_parity, err_wcheck, err_timing} = 4'b1000 >> e;
      pulse(1, 0, 0, 0);
      chk_addr("R3 error holds", 3, 19, 9, 0);
      // R9: maintenance ignores errors
      pulse(0, 1, 0, 0);
      chk_addr("R9 maint over error", 4, 0, 0, 0);
      {err_write, err_parity, err_wcheck, err_timing} = 4'b0000;
    end

    // R4 and R9 in format mode
    fmt_mode = 1;
    do_load(0, 3, 4);
    pulse(1, 0, 0, 0);
    chk_addr("R4 format holds", 0, 3, 4, 0);
    pulse(0, 1, 0, 0);
    chk_addr("R9 maint in format", 0, 3, 5, 0);
    fmt_mode = 0;

    // R10 priority
    do_load(2, 2, 2);
    load_data = {CW'(3), HW'(3), SW'(3)};
    pulse(1, 0, 1, 1);
    chk_addr("R10 clr beats load", 0, 0, 0, 0);
    pulse(1, 1, 0, 1);
    chk_addr("R10 load beats step", 3, 3, 3, 0);

    // R11: sweep every code
    for (int c = 0; c < 256; c++) begin
      do_load(c, 0, 0);
      chk("R11 bad_cyl", int'(bad_cyl), int'(c > CMAX));
      chk("R11 cyl load", int'(cyl), c);
    end
    for (int h = 0; h < 32; h++) begin
      do_load(0, h, 0);
      chk("R11 bad_head", int'(bad_head), int'(h > HMAX));
    end
    for (int s = 0; s < 16; s++) begin
      do_load(0, 0, s);
      chk("R11 bad_sec", int'(bad_sec), int'(s > SMAX));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule